// File: doc/BRIEF.md
# Integer ALU with Zero and Overflow Flags

A combinational arithmetic and logic unit for the execute stage of a simple load/store processor. It takes two 32-bit operands and a 3-bit operation code. It returns a 32-bit result, a flag that is set when the result is zero, and a two's-complement overflow flag. The overflow flag is only reported. An external trap unit decides what to do with it.

The add and subtract paths share one adder. For a subtract, the second operand is inverted and a carry of one is fed in. The signed less-than comparison is taken from that adder: the sign of the difference is XORed with the subtract overflow, so the answer stays correct when the difference overflows. Equality is tested by subtracting and reading the zero flag. Two spare codes provide XOR and signed maximum. The maximum reuses the corrected less-than signal.

There is no clock and no state. The outputs follow the inputs within the same cycle, so the unit has no stream interface and no back-pressure rules.

Top module: `intalu_top`

## Requirements
- R1: Code 000 returns the bitwise AND of the operands, and code 001 returns the bitwise OR.
- R2: Code 010 returns the sum of the operands modulo 2^32.
- R3: Code 110 returns the first operand plus the bitwise inverse of the second operand plus one, which is the difference modulo 2^32.
- R4: Code 111 returns 1 in bit 0 and zeros in bits 31..1 when the first operand is less than the second as signed values, and all zeros otherwise. This holds even when the difference overflows.
- R5: The zero flag is 1 exactly when all 32 result bits are 0. With code 110 it is therefore 1 exactly when the operands are equal.
- R6: For code 010, the overflow flag is 1 exactly when both operands have the same sign bit and the result sign bit differs from it.
- R7: For code 110, the overflow flag is 1 exactly when a non-negative value minus a negative value gives a negative result, or a negative value minus a non-negative value gives a non-negative result.
- R8: For every code other than 010 and 110, the overflow flag is 0.
- R9: Code 011 returns the bitwise XOR of the operands.
- R10: Code 100 returns whichever operand is larger as a signed value. This holds even when the difference of the operands overflows.
- R11: Code 101 is unused. It returns a result of zero, so the zero flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sel | input | 3 | Operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
Directed operand pairs sit at the signed range edges: the largest positive value, the most negative value, -1, 0 and 1. Each pair is applied under all eight codes. These pairs separate a correct overflow rule from one that looks only at the carry out or only at the result sign. They also separate a corrected less-than from one that reads the raw sign of the difference; the most negative value against 1 is the case that does this. Equal operands under subtraction test the equality use of the zero flag. A long pseudo-random run over all codes then compares every output against a reference built on wide signed integers. That reference shares no structure with the inverted-operand adder.

// File: rtl/intalu_pkg.sv
package intalu_pkg;
  typedef enum logic [2:0] {
    OP_AND  = 3'b000,
    OP_OR   = 3'b001,
    OP_ADD  = 3'b010,
    OP_XOR  = 3'b011,
    OP_MAX  = 3'b100,
    OP_NONE = 3'b101,
    OP_SUB  = 3'b110,
    OP_SLT  = 3'b111
  } alu_op_e;
endpackage

// File: rtl/intalu_addsub.sv
module intalu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf,
  output logic         lt
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;

  // invert the second operand and inject a carry of one for subtraction
  assign b_eff = b ^ {W{sub}};
  assign sum   = a + b_eff + {{(W-1){1'b0}}, sub};
  // overflow: operands as added share a sign, result sign differs
  assign ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  // corrected signed less-than, valid when sub is set
  assign lt    = sum[MSB] ^ ovf;

  always_comb begin
    if (!sub && ovf)
      AST_ADD_OVF_SIGNS: assert (a[MSB] == b[MSB]); // R6
    if (sub && ovf)
      AST_SUB_OVF_SIGNS: assert (a[MSB] != b[MSB]); // R7
  end
endmodule

// File: rtl/intalu_logic.sv
module intalu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] xor_o
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign and_o[i] = a[i] & b[i];
      assign or_o[i]  = a[i] | b[i];
      assign xor_o[i] = a[i] ^ b[i];
    end
  endgenerate
endmodule

// File: rtl/intalu_top.sv
module intalu_top
  import intalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   op_sel,
  output logic [W-1:0] result,
  output logic         zero,
  output logic         ovf
);
  logic [W-1:0] sum_w, and_w, or_w, xor_w;
  logic         as_ovf, as_lt;

  intalu_addsub #(.W(W)) u_addsub (
    .a(op_a), .b(op_b), .sub(op_sel[2]),
    .sum(sum_w), .ovf(as_ovf), .lt(as_lt)
  );

  intalu_logic #(.W(W)) u_logic (
    .a(op_a), .b(op_b),
    .and_o(and_w), .or_o(or_w), .xor_o(xor_w)
  );

  always_comb begin
    unique case (op_sel)
      OP_AND:  result = and_w;
      OP_OR:   result = or_w;
      OP_ADD:  result = sum_w;
      OP_XOR:  result = xor_w;
      OP_MAX:  result = as_lt ? op_b : op_a;
      OP_SUB:  result = sum_w;
      OP_SLT:  result = {{(W-1){1'b0}}, as_lt};
      default: result = '0;
    endcase
  end

  assign zero = ~|result;
  assign ovf  = ((op_sel == OP_ADD) || (op_sel == OP_SUB)) && as_ovf;

  always_comb begin
    if (op_sel == OP_SLT) begin
      AST_SLT_UPPER_CLEAR: assert (result[W-1:1] == '0); // R4
      AST_SLT_SIGNED: assert (result[0] == ($signed(op_a) < $signed(op_b))); // R4
    end
    if ((op_sel == OP_SUB) && zero)
      AST_SUB_EQUAL: assert (op_a == op_b); // R5
    if ((op_sel != OP_ADD) && (op_sel != OP_SUB))
      AST_NO_OVERFLOW: assert (!ovf); // R8
    if (op_sel == OP_MAX)
      AST_MAX_PICK: assert (($signed(result) >= $signed(op_a)) && ($signed(result) >= $signed(op_b))); // R10
    if (op_sel == OP_NONE)
      AST_UNUSED_ZERO: assert (zero && (result == '0)); // R11
  end
endmodule

// File: tb/intalu_top_test.sv
module intalu_top_test;
  logic        clk = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [2:0]  op = 3'b000;
  logic [31:0] result;
  logic        zero, ovf;
  int checks = 0, errors = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #2 clk = ~clk; // 4 time units per period: 250 MHz on a 1 ns unit

  intalu_top uut (.op_a(a), .op_b(b), .op_sel(op), .result(result), .zero(zero), .ovf(ovf));

  function automatic string res_tag(input logic [2:0] o);
    case (o)
      3'd0, 3'd1: return "R1";
      3'd2: return "R2";
      3'd3: return "R9";
      3'd4: return "R10";
      3'd5: return "R11";
      3'd6: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", tag, op, a, b, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] ta, input logic [31:0] tb, input logic [2:0] to);
    longint sa, sb, wide;
    logic [31:0] er;
    logic eo;
    @(posedge clk);
    #1;
    a = ta; b = tb; op = to;
    sa = longint'($signed(ta));
    sb = longint'($signed(tb));
    eo = 1'b0;
    case (to)
      3'd0: er = ta & tb;
      3'd1: er = ta | tb;
      3'd2: begin wide = sa + sb; er = wide[31:0];
                  eo = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
      3'd3: er = ta ^ tb;
      3'd4: er = (sa > sb) ? ta : tb;
      3'd6: begin wide = sa - sb; er = wide[31:0];
                  eo = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
      3'd7: er = (sa < sb) ? 32'd1 : 32'd0;
      default: er = 32'd0;
    endcase
    @(negedge clk);
    check(res_tag(to), result, er);
    check("R5", {31'd0, zero}, {31'd0, er == 32'd0});
    check((to == 3'd2) ? "R6" : (to == 3'd6) ? "R7" : "R8", {31'd0, ovf}, {31'd0, eo});
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] edges [6];
    edges = '{32'h7fff_ffff, 32'h8000_0000, 32'hffff_ffff, 32'h0, 32'h1, 32'h1234_5678};
    // starting state: all-zero inputs under AND give a zero result (R1, R5)
    @(negedge clk);
    check("R1", result, 32'h0);
    check("R5", {31'd0, zero}, 32'd1);
    // edge pairs under every code (R1..R11)
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int o = 0; o < 8; o++)
          run(edges[i], edges[j], 3'(o));
    // named corners
    run(32'h8000_0000, 32'h1, 3'd7);        // R4: difference overflows
    run(32'h8000_0000, 32'h1, 3'd4);        // R10
    run(32'h7fff_ffff, 32'h1, 3'd2);        // R6
    run(32'h7fff_ffff, 32'hffff_ffff, 3'd6);// R7
    run(32'hdead_beef, 32'hdead_beef, 3'd6);// R5 equality
    run(32'hdead_beef, 32'h1, 3'd5);        // R11
    // pseudo-random sweep
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] ra, rb;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      ra = rng;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      rb = (n % 5 == 0) ? ra : rng;
      run(ra, rb, 3'(n % 8));
    end
    finish_up();
  end
endmodule